// File: doc/BRIEF.md
# Sampled External Interrupt Input Conditioner

This block sits between eight asynchronous external interrupt pins and a downstream edge detector. Each pin first crosses into the system clock domain through a two-flop synchroniser. A conditioned level is then produced for each line. A line either follows its synchronised input on every system clock, or it updates only when a shared sampling tick occurs. That tick filters narrow glitches and slows the rate at which the line can change.

The sampling tick is a one-cycle enable in the system clock domain. No derived clock is generated. The block synchronises two slow reference clocks, a low-speed one and a high-speed one, and picks one of them. It counts rising edges of the picked clock and raises the tick on every 2^k-th edge, where k comes from a three-bit divider code. A single 16-bit mode register holds the source select, the divider code and eight per-line sample enables. Software writes the register with byte enables. Its contents are always visible on a registered read port.

Top module: `extint_sampler`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rd_data` reads 0x0000 and `irq_level` reads 0x00.
- R2: A write with `wr_en` high updates only the bytes whose `wr_be` bit is set. Bit 0 of `wr_be` covers bits 7:0 and bit 1 covers bits 15:8. `rd_data` shows the stored value two rising edges after the write edge. A write with `wr_be` = 00 changes nothing.
- R3: Bits 15, 11, 9 and 8 always read 0, and writes to them are ignored. Bits 14:12 hold the divider code, bit 10 holds the source select, and bits 7:0 hold the sample enables, with bit n controlling line n.
- R4: A line whose enable bit is 0 drives `irq_level[n]` equal to `irq_in[n]` as it was three system clocks earlier. The first change shows after the third rising edge following the input change.
- R5: A line whose enable bit is 1 keeps its output unchanged while no sampling tick occurs. This holds for any input activity and for any edges on the reference clock that is not selected.
- R6: Divider codes 0 to 6 give a tick on every 1, 2, 4, 8, 16, 32 or 64-th rising edge of the selected reference clock, counted from the last restart. A sampled line then takes its synchronised input.
- R7: Divider code 7 behaves exactly like code 0: every rising edge of the selected reference gives a tick.
- R8: When bit 10 is 0, `src_lo` drives the tick. When bit 10 is 1, `src_hi` drives the tick.
- R9: A write that changes the divider code or the source select clears the edge count. The next tick comes after a full 2^k edges of the newly chosen setting.
- R10: Each line chooses sampled or unsampled detection on its own. With mixed enables, unsampled lines follow their input while sampled lines wait for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_be | input | 2 | Byte enables for the write (bit 1 = high byte) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered readback of the mode register |
| src_lo | input | 1 | Low-speed sampling reference, asynchronous |
| src_hi | input | 1 | High-speed sampling reference, asynchronous |
| irq_in | input | 8 | Asynchronous external interrupt lines |
| irq_level | output | 8 | Conditioned levels for the edge detector |

## Verification
Suppose the prescaler count goes wrong, for example a restart that does not happen or a code 7 that is not aliased. A sampled line then moves on the wrong reference edge. The bench pulses the reference one edge at a time and checks the line after each pulse, so such a fault shows within one reference pulse of the expected tick. A fault in a synchroniser stage or in the bypass mux shifts the unsampled latency away from exactly three cycles, and that shows at the first input change. A fault in the register write path shows on `rd_data` two cycles after the write.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int LINES     = 8;
  localparam int DIV_W     = 3;
  localparam int MAX_SHIFT = 6;
  localparam int CNT_W     = MAX_SHIFT;
  localparam int REG_W     = 16;
  localparam int DIV_LSB   = 12;
  localparam int SRC_BIT   = 10;
  localparam logic [REG_W-1:0] WMASK = 16'h74FF;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             src_hi;
    logic [LINES-1:0] samp_en;
  } mode_t;

  // Edge count at which the tick fires; the unused top code aliases to divide-by-1
  function automatic logic [CNT_W-1:0] div_limit(input logic [DIV_W-1:0] code);
    logic [CNT_W:0] one_hot;
    if (int'(code) > MAX_SHIFT) begin
      return '0;
    end
    one_hot = (CNT_W+1)'(1) << code;
    return CNT_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg[0] <= '0;
    end else begin
      stg[0] <= d;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[i] <= '0;
      end else begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/extint_mode_reg.sv
module extint_mode_reg
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [REG_W-1:0] wr_data,
  output mode_t            mode_o,
  output logic             restart_o,
  output logic [REG_W-1:0] rd_data
);
  mode_t            mode_q;
  mode_t            mode_d;
  logic [REG_W-1:0] packed_val;

  always_comb begin
    mode_d = mode_q;
    if (wr_en && wr_be[0]) begin
      mode_d.samp_en = wr_data[LINES-1:0];
    end
    if (wr_en && wr_be[1]) begin
      mode_d.div    = wr_data[DIV_LSB +: DIV_W];
      mode_d.src_hi = wr_data[SRC_BIT];
    end
  end

  // Restart only when the tick timing actually changes
  assign restart_o = (mode_d.div != mode_q.div) || (mode_d.src_hi != mode_q.src_hi);

  always_comb begin
    packed_val                     = '0;
    packed_val[LINES-1:0]          = mode_q.samp_en;
    packed_val[SRC_BIT]            = mode_q.src_hi;
    packed_val[DIV_LSB +: DIV_W]   = mode_q.div;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      rd_data <= '0;
    end else begin
      mode_q  <= mode_d;
      rd_data <= packed_val & WMASK;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/extint_tick_gen.sv
module extint_tick_gen
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             src_lo,
  input  logic             src_hi,
  input  logic             sel_hi,
  input  logic [DIV_W-1:0] div_code,
  input  logic             restart,
  output logic             tick_o
);
  logic [1:0]       src_s;
  logic             sel;
  logic             prev_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  extint_sync #(.W(2), .STAGES(2)) u_src_sync (
    .clk (clk),
    .rst (rst),
    .d   ({src_hi, src_lo}),
    .q   (src_s)
  );

  assign sel   = sel_hi ? src_s[1] : src_s[0];
  assign rise  = sel & ~prev_q;
  assign limit = div_limit(div_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      prev_q <= sel;
      tick_o <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
      end else if (rise) begin
        if (cnt_q >= limit) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/extint_line.sv
module extint_line (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic samp_en,
  input  logic tick,
  output logic level_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b0;
    end else if (!samp_en || tick) begin
      level_o <= sync_in;
    end
  end
endmodule

// File: rtl/extint_sampler.sv
module extint_sampler
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             src_lo,
  input  logic             src_hi,
  input  logic [LINES-1:0] irq_in,
  output logic [LINES-1:0] irq_level
);
  mode_t            mode;
  logic             restart;
  logic             samp_tick;
  logic [LINES-1:0] irq_sync;

  extint_mode_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .mode_o    (mode),
    .restart_o (restart),
    .rd_data   (rd_data)
  );

  extint_tick_gen u_tick (
    .clk      (clk),
    .rst      (rst),
    .src_lo   (src_lo),
    .src_hi   (src_hi),
    .sel_hi   (mode.src_hi),
    .div_code (mode.div),
    .restart  (restart),
    .tick_o   (samp_tick)
  );

  extint_sync #(.W(LINES), .STAGES(2)) u_in_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (irq_sync)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    extint_line u_line (
      .clk     (clk),
      .rst     (rst),
      .sync_in (irq_sync[n]),
      .samp_en (mode.samp_en[n]),
      .tick    (samp_tick),
      .level_o (irq_level[n])
    );
  end
endmodule

// File: rtl/extint_sampler_chk.sv
module extint_sampler_chk
  import extint_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] rd_data,
  input logic [LINES-1:0] irq_in,
  input logic [LINES-1:0] irq_level,
  input logic [LINES-1:0] samp_en,
  input logic             tick,
  input logic             restart
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
    end else if (age != 2'd3) begin
      age <= age + 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && irq_level == '0));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~WMASK) == '0);

  // R4
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (((irq_level ^ $past(irq_in, 3)) & ~$past(samp_en)) == '0));

  // R5
  sampled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (((irq_level ^ $past(irq_level)) & $past(samp_en)
                        & ~{LINES{$past(tick)}}) == '0));

  // R6
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R9
  restart_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

bind extint_sampler extint_sampler_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_data   (rd_data),
  .irq_in    (irq_in),
  .irq_level (irq_level),
  .samp_en   (mode.samp_en),
  .tick      (samp_tick),
  .restart   (restart)
);

// File: tb/sim_extint_sampler.sv
`timescale 1ns/1ps
module sim_extint_sampler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        src_lo = 1'b0;
  logic        src_hi = 1'b0;
  logic [7:0]  irq_in = '0;
  logic [7:0]  irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  extint_sampler u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .src_lo(src_lo), .src_hi(src_hi),
    .irq_in(irq_in), .irq_level(irq_level)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic pulse(input bit hi);
    if (hi) src_hi = 1'b1; else src_lo = 1'b1;
    cycles(4);
    if (hi) src_hi = 1'b0; else src_lo = 1'b0;
    cycles(4);
  endtask

  function automatic logic [15:0] mode(input int dv, input bit s, input logic [7:0] en);
    return {1'b0, dv[2:0], 1'b0, s, 2'b00, en};
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    cycles(3);
    chk("R1 rd_data in reset", rd_data, 16'h0000);
    chk("R1 irq_level in reset", {8'h00, irq_level}, 16'h0000);
    rst = 1'b0;
    cycles(1);
    chk("R1 rd_data after reset", rd_data, 16'h0000);
    chk("R1 irq_level after reset", {8'h00, irq_level}, 16'h0000);
  endtask

  task automatic t_regs;
    wr(16'h34C3, 2'b11); cycles(1);
    chk("R2 word write", rd_data, 16'h34C3);
    wr(16'hFF5A, 2'b01); cycles(1);
    chk("R2 low byte write", rd_data, 16'h345A);
    wr(16'h6B00, 2'b10); cycles(1);
    chk("R2 high byte write", rd_data, 16'h605A);
    wr(16'hFFFF, 2'b11); cycles(1);
    chk("R3 reserved bits", rd_data, 16'h74FF);
    wr(16'h0000, 2'b00); cycles(1);
    chk("R2 no byte enable", rd_data, 16'h74FF);
    wr(16'h0000, 2'b11); cycles(1);
    chk("R2 clear", rd_data, 16'h0000);
  endtask

  task automatic t_bypass;
    irq_in = 8'h00; cycles(4);
    irq_in = 8'h3C;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 before latency", {8'h00, irq_level}, 16'h0000);
    cycles(1);
    chk("R4 at latency", {8'h00, irq_level}, 16'h003C);
    irq_in = 8'h00; cycles(4);
    chk("R4 follow low", {8'h00, irq_level}, 16'h0000);
  endtask

  task automatic t_hold;
    wr(mode(0, 0, 8'hFF), 2'b11);
    irq_in = 8'hA5; cycles(20);
    chk("R5 held without tick", {8'h00, irq_level}, 16'h0000);
    pulse(1'b1);
    chk("R5 unselected source ignored", {8'h00, irq_level}, 16'h0000);
    pulse(1'b0);
    chk("R6 code 0 single edge", {8'h00, irq_level}, 16'h00A5);
  endtask

  task automatic t_div(input int code);
    int n;
    logic cur;
    string req;
    n = (code == 7) ? 1 : (1 << code);
    req = (code == 7) ? "R7" : "R6";
    cur = irq_level[0];
    wr(mode(code, 0, 8'h01), 2'b11);
    irq_in[0] = ~cur; cycles(4);
    for (int i = 0; i < n - 1; i++) pulse(1'b0);
    chk($sformatf("%s code %0d before tick", req, code), {15'd0, irq_level[0]}, {15'd0, cur});
    pulse(1'b0);
    chk($sformatf("%s code %0d at tick", req, code), {15'd0, irq_level[0]}, {15'd0, ~cur});
  endtask

  task automatic t_src;
    logic cur;
    cur = irq_level[0];
    wr(mode(0, 1, 8'h01), 2'b11);
    irq_in[0] = ~cur; cycles(4);
    repeat (3) pulse(1'b0);
    chk("R8 low source ignored when high selected", {15'd0, irq_level[0]}, {15'd0, cur});
    pulse(1'b1);
    chk("R8 high source ticks", {15'd0, irq_level[0]}, {15'd0, ~cur});
  endtask

  task automatic t_restart;
    logic cur;
    cur = irq_level[0];
    wr(mode(2, 0, 8'h01), 2'b11);
    irq_in[0] = ~cur; cycles(4);
    repeat (2) pulse(1'b0);
    chk("R9 partial count", {15'd0, irq_level[0]}, {15'd0, cur});
    wr(mode(3, 0, 8'h01), 2'b11);
    repeat (7) pulse(1'b0);
    chk("R9 count restarted", {15'd0, irq_level[0]}, {15'd0, cur});
    pulse(1'b0);
    chk("R9 full count after restart", {15'd0, irq_level[0]}, {15'd0, ~cur});
  endtask

  task automatic t_mixed;
    wr(mode(0, 0, 8'h00), 2'b11);
    irq_in = 8'h00; cycles(5);
    chk("R10 all clear", {8'h00, irq_level}, 16'h0000);
    wr(mode(0, 0, 8'hA5), 2'b01);
    irq_in = 8'hFF; cycles(6);
    chk("R10 mixed before tick", {8'h00, irq_level}, 16'h005A);
    pulse(1'b0);
    chk("R10 mixed after tick", {8'h00, irq_level}, 16'h00FF);
  endtask

  initial begin
    t_reset;
    t_regs;
    t_bypass;
    t_hold;
    for (int c = 1; c <= 7; c++) t_div(c);
    t_div(0);
    t_src;
    t_restart;
    t_mixed;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule